// File: doc/BRIEF.md
# Idle-Strobe Power-Down and Clock-Enable Controller

This block handles power management for a memory device that sits on a microcontroller's host bus. It watches the host's address-latch strobe. Each clock, it checks whether the strobe has changed level since the previous clock. When automatic power-down is switched on and the strobe has stayed at one level for a run of input clocks, the block raises a power-down state. The first later change on the strobe clears that state again.

A small control register sits behind a simple address, write-data and write-strobe port, and it can be read back through the same port. It holds the automatic power-down enable. It also holds two clock-cut bits: one removes the input clock from the programmable logic array, and the other removes it from the output macrocells. An active-low chip-select input decides which memory banks are enabled. Each memory enable is active only when chip select is low and the device is not powered down. The I/O enable follows chip select alone.

Top module: `apd_clock_ctrl`

## Requirements
- R1: After reset the control register reads 0, power-down is low, both clock enables are 1, and each memory enable equals the inverse of chip select.
- R2: A write with address 0 stores the write data into the control register, which reads back at address 0 from the next cycle. Any other address reads 0, and a write to it leaves the control register unchanged.
- R3: Control bit 4 set to 1 drives the logic-array clock enable to 0. Bit 4 at 0 drives it to 1.
- R4: Control bit 5 set to 1 drives the macrocell clock enable to 0. Bit 5 at 0 drives it to 1.
- R5: While control bit 1 is 0, power-down never asserts, however long the strobe stays idle.
- R6: While control bit 1 is 1, the idle count goes up by one on each clock edge at which the strobe has not changed. Power-down asserts at the edge where the count reaches 15.
- R7: A change of the strobe level in either direction, seen at a clock edge, clears power-down at that edge and restarts the idle count from zero.
- R8: Each of the three memory enables is 1 exactly when chip select is 0 and power-down is 0. The I/O enable is 1 exactly when chip select is 0, whatever the power-down state.
- R9: Clearing control bit 1 while the device is powered down clears power-down at the next clock edge.
- R10: The two clock enables follow only their control bits. Neither chip select nor power-down changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Host address-latch strobe |
| cs_n | input | 1 | Active-low chip select |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data |
| pdn | output | 1 | Power-down state |
| mem_en | output | 3 | Enables for primary flash, secondary flash, SRAM |
| io_en | output | 1 | I/O block enable |
| array_clk_en | output | 1 | Clock enable for the logic array |
| mcell_clk_en | output | 1 | Clock enable for the output macrocells |

## Verification
The assertions run on every cycle. They check that power-down only appears while it is enabled and only after a full run of idle edges, and that a strobe change or a cleared enable drops it on the next edge. They also check that memory enables stay off whenever the device is powered down or deselected, and that register writes reach the clock enables.

Some behaviour shows up only in the bench's scenarios, which compare against a reference model:
- the exact edge at which the fifteenth idle cycle sets power-down;
- an idle run of fourteen cycles broken by an edge, which must not set it;
- readback through off-map addresses;
- the clock enables staying unchanged while power-down and chip select move.

// File: rtl/apd_pkg.sv
package apd_pkg;
   localparam int unsigned APD_EN_BIT   = 1;
   localparam int unsigned ARR_GATE_BIT = 4;
   localparam int unsigned MC_GATE_BIT  = 5;

   typedef struct packed {
      logic apd_en;
      logic arr_gate;
      logic mc_gate;
   } apd_ctl_t;
endpackage

// File: rtl/apd_ctl_reg.sv
module apd_ctl_reg
   import apd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTL_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output apd_ctl_t          ctl
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTL_ADDR);

   if (DATA_W <= MC_GATE_BIT) begin : g_bad_width
      $error("DATA_W too narrow for control bits");
   end
   if (CTL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("CTL_ADDR outside address space");
   end

   logic [DATA_W-1:0] ctl_q;
   logic              hit;

   assign hit = (addr == HIT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (we && hit) ctl_q <= wdata;
   end

   assign rdata        = hit ? ctl_q : '0;
   assign ctl.apd_en   = ctl_q[APD_EN_BIT];
   assign ctl.arr_gate = ctl_q[ARR_GATE_BIT];
   assign ctl.mc_gate  = ctl_q[MC_GATE_BIT];
endmodule

// File: rtl/apd_idle_timer.sv
module apd_idle_timer #(
   parameter int unsigned IDLE_LIMIT = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ale,
   output logic pdn
);
   localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);
   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(IDLE_LIMIT);

   if (IDLE_LIMIT < 2) begin : g_bad_limit
      $error("IDLE_LIMIT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ale_q, act;
   logic             pdn_q;

   assign act = ale ^ ale_q;

   always_comb begin
      if (!enable || act)      cnt_d = '0;
      else if (cnt_q != LIMIT_C) cnt_d = cnt_q + 1'b1;
      else                     cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ale_q <= 1'b0;
         pdn_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         ale_q <= ale;
         pdn_q <= (cnt_d == LIMIT_C);
      end
   end

   assign pdn = pdn_q;
endmodule

// File: rtl/apd_enable_gen.sv
module apd_enable_gen
   import apd_pkg::*;
#(
   parameter int unsigned NUM_MEM      = 3,
   parameter logic [NUM_MEM-1:0] PD_MASK = '1
) (
   input  logic               cs_n,
   input  logic               pdn,
   input  apd_ctl_t           ctl,
   output logic [NUM_MEM-1:0] mem_en,
   output logic               io_en,
   output logic               array_clk_en,
   output logic               mcell_clk_en
);
   if (NUM_MEM < 1) begin : g_bad_num
      $error("NUM_MEM must be at least 1");
   end

   for (genvar b = 0; b < NUM_MEM; b++) begin : g_bank
      if (PD_MASK[b]) begin : g_pd
         assign mem_en[b] = !cs_n && !pdn;
      end else begin : g_nopd
         assign mem_en[b] = !cs_n;
      end
   end

   assign io_en        = !cs_n;
   assign array_clk_en = !ctl.arr_gate;
   assign mcell_clk_en = !ctl.mc_gate;
endmodule

// File: rtl/apd_clock_ctrl.sv
module apd_clock_ctrl
   import apd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_MEM    = 3,
   parameter int unsigned IDLE_LIMIT = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ale,
   input  logic               cs_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_we,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               pdn,
   output logic [NUM_MEM-1:0] mem_en,
   output logic               io_en,
   output logic               array_clk_en,
   output logic               mcell_clk_en
);
   apd_ctl_t ctl_s;

   apd_ctl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(0)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .ctl(ctl_s)
   );

   apd_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(ctl_s.apd_en), .ale(ale), .pdn(pdn)
   );

   apd_enable_gen #(.NUM_MEM(NUM_MEM)) u_en (
      .cs_n(cs_n), .pdn(pdn), .ctl(ctl_s), .mem_en(mem_en), .io_en(io_en),
      .array_clk_en(array_clk_en), .mcell_clk_en(mcell_clk_en)
   );
endmodule

// File: rtl/apd_clock_ctrl_chk.sv
module apd_clock_ctrl_chk #(
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_MEM    = 3,
   parameter int unsigned IDLE_LIMIT = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ale,
   input logic               cs_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic               reg_we,
   input logic               pdn,
   input logic [NUM_MEM-1:0] mem_en,
   input logic               array_clk_en,
   input logic               mcell_clk_en,
   input logic               apd_en
);
   logic [31:0] idle_q;
   logic        ale_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q   <= '0;
         ale_prev <= 1'b0;
      end else begin
         ale_prev <= ale;
         if (!apd_en || ale != ale_prev) idle_q <= '0;
         else if (idle_q < IDLE_LIMIT)   idle_q <= idle_q + 1;
      end
   end

   // R5
   pdn_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn) |-> $past(apd_en));

   // R6
   pdn_after_idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn) |-> idle_q == IDLE_LIMIT);

   // R7
   strobe_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(ale) |=> !pdn);

   // R9
   disable_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !apd_en |=> !pdn);

   // R8
   mem_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn || cs_n) |-> mem_en == '0);

   // R3
   array_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == '0) |=> array_clk_en == !$past(reg_wdata[4]));

   // R4
   mcell_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == '0) |=> mcell_clk_en == !$past(reg_wdata[5]));

   // R10
   gates_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_we) |-> $stable(array_clk_en) && $stable(mcell_clk_en));
endmodule

bind apd_clock_ctrl apd_clock_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_MEM(NUM_MEM), .IDLE_LIMIT(IDLE_LIMIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_we(reg_we), .pdn(pdn), .mem_en(mem_en),
   .array_clk_en(array_clk_en), .mcell_clk_en(mcell_clk_en), .apd_en(ctl_s.apd_en)
);

// File: tb/tb_apd_clock_ctrl.sv
`timescale 1ns/1ps
module tb_apd_clock_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ale = 1'b0;
   logic       cs_n = 1'b1;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_rdata;
   logic       pdn, io_en, array_clk_en, mcell_clk_en;
   logic [2:0] mem_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   apd_clock_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .pdn(pdn),
      .mem_en(mem_en), .io_en(io_en), .array_clk_en(array_clk_en),
      .mcell_clk_en(mcell_clk_en)
   );

   // behavioural reference model
   integer     m_idle;
   bit         m_pdn;
   logic [7:0] m_ctl;
   logic       m_ale_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idle = 0; m_pdn = 0; m_ctl = 8'h00; m_ale_prev = 1'b0;
      end else begin
         if (!m_ctl[1] || ale !== m_ale_prev) begin
            m_idle = 0; m_pdn = 0;
         end else begin
            if (m_idle < 15) m_idle = m_idle + 1;
            m_pdn = (m_idle == 15);
         end
         m_ale_prev = ale;
         if (reg_we && reg_addr == 2'd0) m_ctl = reg_wdata;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R6/R7 pdn", 32'(pdn), 32'(m_pdn));
      chk("R2 rdata", 32'(reg_rdata), (reg_addr == 2'd0) ? 32'(m_ctl) : 32'd0);
      chk("R3 array_clk_en", 32'(array_clk_en), 32'(!m_ctl[4]));
      chk("R4 mcell_clk_en", 32'(mcell_clk_en), 32'(!m_ctl[5]));
      chk("R8 mem_en", 32'(mem_en), (!cs_n && !m_pdn) ? 32'd7 : 32'd0);
      chk("R8 io_en", 32'(io_en), 32'(!cs_n));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_n) compare_all();
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      step(1);
      reg_we = 1'b0; reg_addr = 2'd0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 rdata", 32'(reg_rdata), 32'd0);
      chk("R1 pdn", 32'(pdn), 32'd0);
      chk("R1 clk enables", 32'({array_clk_en, mcell_clk_en}), 32'd3);
      chk("R1 mem_en", 32'(mem_en), 32'd0);
      cs_n = 1'b0;
      step(1);
      chk("R1 mem_en selected", 32'(mem_en), 32'd7);

      // R3 R4 clock cut bits
      wr(2'd0, 8'h30);
      step(1);
      chk("R3 array gated", 32'(array_clk_en), 32'd0);
      chk("R4 mcell gated", 32'(mcell_clk_en), 32'd0);
      wr(2'd0, 8'h10);
      step(1);
      chk("R4 mcell restored", 32'(mcell_clk_en), 32'd1);

      // R5 disabled: long idle, no power-down
      wr(2'd0, 8'h00);
      step(40);
      chk("R5 no pdn when disabled", 32'(pdn), 32'd0);

      // R6 enabled idle run
      wr(2'd0, 8'h02);
      step(20);
      chk("R6 pdn after idle run", 32'(pdn), 32'd1);
      chk("R8 mem off in pdn", 32'(mem_en), 32'd0);
      chk("R8 io on in pdn", 32'(io_en), 32'd1);

      // R7 rising strobe wakes
      ale = 1'b1;
      step(1);
      chk("R7 wake on rise", 32'(pdn), 32'd0);
      step(20);
      ale = 1'b0;
      step(1);
      chk("R7 wake on fall", 32'(pdn), 32'd0);

      // R7 periodic activity keeps it awake
      for (int k = 0; k < 6; k++) begin
         step(10);
         ale = ~ale;
      end
      chk("R7 periodic activity", 32'(pdn), 32'd0);

      // R6/R7 run of 14 broken by edge then full run
      step(14);
      ale = ~ale;
      step(14);
      chk("R7 restart count", 32'(pdn), 32'd0);
      step(3);
      chk("R6 pdn after restart", 32'(pdn), 32'd1);

      // R10 gates independent of pdn and cs_n
      wr(2'd0, 8'h32);
      cs_n = 1'b1;
      step(5);
      chk("R10 gates under pdn", 32'({array_clk_en, mcell_clk_en}), 32'd0);
      cs_n = 1'b0;
      step(1);
      chk("R10 gates with cs", 32'({array_clk_en, mcell_clk_en}), 32'd0);

      // R2 off-map address
      wr(2'd1, 8'hFF);
      wr(2'd3, 8'h00);
      reg_addr = 2'd2;
      step(1);
      chk("R2 offmap read", 32'(reg_rdata), 32'd0);
      reg_addr = 2'd0;
      step(1);
      chk("R2 ctl unchanged", 32'(reg_rdata), 32'h32);

      // R9 clear enable while powered down
      step(20);
      chk("R9 pdn before clear", 32'(pdn), 32'd1);
      wr(2'd0, 8'h00);
      step(1);
      chk("R9 pdn cleared", 32'(pdn), 32'd0);
      step(5);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule